// File: doc/BRIEF.md
# Dual-Mode Sample Serializer Lanes

This block turns parallel converter samples from a set of independent channels (two by default) into bit-serial streams. Each channel owns a primary lane and a secondary lane. A free-running word counter, clocked by the same clock that is forwarded to the receiver, captures one sample per channel every `SMP_W` active clock edges. All lane bits change on that clock's rising edge.

In single-lane mode every captured sample leaves on the primary lane at one bit per clock. The secondary lane is switched off through its enable output. In dual-lane mode the captured samples alternate between the two lanes. Each lane then spends two word periods on one word, so every bit is held for two clocks. A frame strobe per lane marks the first bit of each word. A per-channel range flag reports whether the sample most recently captured was beyond full scale. A power-down input freezes the whole block, so every output keeps its level until power-down is released.

The mode input is treated as static: it may change only while reset is held.

Top module: `ser_lanes`

## Requirements
- R1: In single-lane mode (`dual_i`=0), a sample is captured on the first active edge after reset and on every `SMP_W`-th active edge after that. After a capture edge and the following `SMP_W`-1 active edges, the channel's `ln1_o` bit presents that sample's bits from MSB down to LSB, one bit per edge.
- R2: In dual-lane mode (`dual_i`=1), the first sample captured after reset goes to lane 1, the next to lane 0, and so on alternately. Each bit is held for two active edges, MSB first, so a word occupies 2·`SMP_W` edges. Lane 0 stays low until its first word is loaded.
- R3: `ln0_en_o` is low in reset and in single-lane mode. In dual-lane mode it is high from the first active edge after reset.
- R4: A lane's frame strobe is high while the lane presents the MSB of a newly loaded word: for one clock in single-lane mode and for two clocks in dual-lane mode. `ln0_frm_o` never rises in single-lane mode, and the two frame strobes of a channel are never high together.
- R5: While `pwr_dn_i` is high at a clock edge, no output changes, no sample is captured and the word position does not advance. After release, the block resumes exactly where it stopped.
- R6: `rng_o` of a channel equals the `ovr_i` bit that was captured together with that channel's most recent sample. It changes only on a capture edge.
- R7: Each channel's lanes carry only that channel's samples, taken from bits [c·`SMP_W` +: `SMP_W`] of `smp_i`.
- R8: A synchronous active-low reset drives all lane bits, frame strobes, lane-0 enables and range flags low, and steers the next sample to lane 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock, also the forwarded output clock |
| rst_n | input | 1 | Synchronous reset, active low |
| pwr_dn_i | input | 1 | Power-down: freeze all state and outputs |
| dual_i | input | 1 | Lane mode: 0 single-lane, 1 dual-lane (static outside reset) |
| smp_i | input | NCH·SMP_W | Parallel samples, channel c at [c·SMP_W +: SMP_W] |
| ovr_i | input | NCH | Per-channel beyond-full-scale bit accompanying each sample |
| ln1_o | output | NCH | Primary serial lane bit per channel |
| ln1_frm_o | output | NCH | Primary lane first-bit strobe per channel |
| ln0_o | output | NCH | Secondary serial lane bit per channel |
| ln0_frm_o | output | NCH | Secondary lane first-bit strobe per channel |
| ln0_en_o | output | NCH | Secondary lane drive enable (low means high impedance) |
| rng_o | output | NCH | Per-channel out-of-range flag |

## Verification
Power-down and a word capture can fall on the same clock edge. When they do, the capture must be skipped and must then happen on the first edge after release, with the data present at that edge. The bench provokes this by raising power-down with a high probability on edges where its own word-position count says a capture is due. It also holds power-down across long runs that straddle capture points and right after reset. The bench judges the result by comparing every lane bit, strobe and flag against a model indexed only by the number of non-frozen edges. Any capture taken during power-down would shift every later expected bit.

// File: rtl/ser_pkg.sv
`timescale 1ns/1ps
// Package: shared defaults and types for the sample serializer.
// Assumes nothing beyond IEEE 1800-2017 packages.
package ser_pkg;

    // Default sample width and channel count.
    localparam int DEF_SMP_W = 12;
    localparam int DEF_NCH   = 2;

    // Lane mode as decoded from the mode input.
    typedef enum logic {
        MODE_SINGLE = 1'b0,
        MODE_DUAL   = 1'b1
    } lane_mode_e;

endpackage

// File: rtl/ser_seq_ctrl.sv
`timescale 1ns/1ps
// Module: ser_seq_ctrl
// Word sequencer shared by all channels. It counts active edges inside a
// word period, raises the capture strobe at position zero and steers each
// capture to lane 1 or lane 0. It also registers the lane-0 enable.
// Assumes: the mode input is static while reset is released; hold freezes
// all state.
module ser_seq_ctrl
    import ser_pkg::*;
#(
    parameter int SMP_W = DEF_SMP_W
) (
    input  logic clk,
    input  logic rst_n,
    input  logic hold,
    input  logic dual,
    output logic cap,
    output logic ld_hi,
    output logic ld_lo,
    output logic slow,
    output logic en_lo
);

    localparam int CW = (SMP_W > 1) ? $clog2(SMP_W) : 1;
    localparam logic [CW-1:0] LAST = CW'(SMP_W - 1);

    lane_mode_e   mode;
    logic [CW-1:0] pos_q;
    logic          to_hi_q;
    logic          en_q;

    // Decode the mode pin into the enum.
    always_comb mode = dual ? MODE_DUAL : MODE_SINGLE;

    // Capture strobe and lane steering for this edge.
    always_comb begin
        cap   = !hold && (pos_q == '0);
        ld_hi = cap && ((mode == MODE_SINGLE) || to_hi_q);
        ld_lo = cap && (mode == MODE_DUAL) && !to_hi_q;
        slow  = (mode == MODE_DUAL);
        en_lo = en_q;
    end

    // Word position, steering toggle and lane-0 enable registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pos_q   <= '0;
            to_hi_q <= 1'b1;
            en_q    <= 1'b0;
        end else if (!hold) begin
            pos_q <= (pos_q == LAST) ? '0 : pos_q + 1'b1;
            if (cap)
                to_hi_q <= (mode == MODE_DUAL) ? !to_hi_q : 1'b1;
            en_q <= (mode == MODE_DUAL);
        end
    end

endmodule

// File: rtl/ser_lane.sv
`timescale 1ns/1ps
// Module: ser_lane
// One serial lane: a shift register loaded with a whole word and shifted MSB
// first. In slow mode each bit is held for two clocks. The frame strobe
// covers the first bit.
// Assumes: load and hold are never both high (the sequencer gates load).
module ser_lane
    import ser_pkg::*;
#(
    parameter int SMP_W = DEF_SMP_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hold,
    input  logic             load,
    input  logic             slow,
    input  logic [SMP_W-1:0] word,
    output logic             bit_o,
    output logic             frm_o
);

    logic [SMP_W-1:0] sh_q;
    logic             ph_q;
    logic             frm_q;

    // Shift register, bit-phase and frame-strobe state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh_q  <= '0;
            ph_q  <= 1'b0;
            frm_q <= 1'b0;
        end else if (!hold) begin
            if (load) begin
                sh_q  <= word;
                ph_q  <= 1'b0;
                frm_q <= 1'b1;
            end else begin
                if (!slow || ph_q)
                    sh_q <= {sh_q[SMP_W-2:0], 1'b0};
                ph_q  <= slow && !ph_q;
                frm_q <= slow && !ph_q && frm_q;
            end
        end
    end

    // The lane presents the register MSB.
    always_comb begin
        bit_o = sh_q[SMP_W-1];
        frm_o = frm_q;
    end

endmodule

// File: rtl/ser_rng_flag.sv
`timescale 1ns/1ps
// Module: ser_rng_flag
// Per-channel out-of-range flag, taken with the sample on each capture.
// Assumes: cap is already low while power-down holds the block.
module ser_rng_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic cap,
    input  logic ovr,
    output logic flag_o
);

    logic flag_q;

    // Capture the range bit alongside the sample.
    always_ff @(posedge clk) begin
        if (!rst_n)
            flag_q <= 1'b0;
        else if (cap)
            flag_q <= ovr;
    end

    // Drive the output from the register.
    always_comb flag_o = flag_q;

endmodule

// File: rtl/ser_lanes.sv
`timescale 1ns/1ps
// Module: ser_lanes (top)
// Serializes NCH converter channels, each onto a primary and a secondary
// lane, in single- or dual-lane mode. One sequencer is shared. Each channel
// has two lanes and a range flag.
// Assumes: dual_i changes only during reset; pwr_dn_i freezes everything.
module ser_lanes
    import ser_pkg::*;
#(
    parameter int SMP_W = DEF_SMP_W,
    parameter int NCH   = DEF_NCH
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 pwr_dn_i,
    input  logic                 dual_i,
    input  logic [NCH*SMP_W-1:0] smp_i,
    input  logic [NCH-1:0]       ovr_i,
    output logic [NCH-1:0]       ln1_o,
    output logic [NCH-1:0]       ln1_frm_o,
    output logic [NCH-1:0]       ln0_o,
    output logic [NCH-1:0]       ln0_frm_o,
    output logic [NCH-1:0]       ln0_en_o,
    output logic [NCH-1:0]       rng_o
);

    logic cap_evt;
    logic ld_hi;
    logic ld_lo;
    logic slow;
    logic en_lo;

    ser_seq_ctrl #(.SMP_W(SMP_W)) u_seq (
        .clk   (clk),
        .rst_n (rst_n),
        .hold  (pwr_dn_i),
        .dual  (dual_i),
        .cap   (cap_evt),
        .ld_hi (ld_hi),
        .ld_lo (ld_lo),
        .slow  (slow),
        .en_lo (en_lo)
    );

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        logic [SMP_W-1:0] word;

        // Slice this channel's sample from the packed input.
        always_comb word = smp_i[c*SMP_W +: SMP_W];

        ser_lane #(.SMP_W(SMP_W)) u_hi (
            .clk   (clk),
            .rst_n (rst_n),
            .hold  (pwr_dn_i),
            .load  (ld_hi),
            .slow  (slow),
            .word  (word),
            .bit_o (ln1_o[c]),
            .frm_o (ln1_frm_o[c])
        );

        ser_lane #(.SMP_W(SMP_W)) u_lo (
            .clk   (clk),
            .rst_n (rst_n),
            .hold  (pwr_dn_i),
            .load  (ld_lo),
            .slow  (slow),
            .word  (word),
            .bit_o (ln0_o[c]),
            .frm_o (ln0_frm_o[c])
        );

        ser_rng_flag u_rng (
            .clk    (clk),
            .rst_n  (rst_n),
            .cap    (cap_evt),
            .ovr    (ovr_i[c]),
            .flag_o (rng_o[c])
        );

        // Fan the shared lane-0 enable out to this channel.
        always_comb ln0_en_o[c] = en_lo;
    end

endmodule

// File: rtl/ser_lanes_chk.sv
`timescale 1ns/1ps
// Module: ser_lanes_chk
// Temporal checks on the serializer ports, attached to ser_lanes by bind.
module ser_lanes_chk #(
    parameter int NCH = 2
) (
    input logic           clk,
    input logic           rst_n,
    input logic           pwr_dn_i,
    input logic           dual_i,
    input logic           cap_evt,
    input logic [NCH-1:0] ln1_o,
    input logic [NCH-1:0] ln1_frm_o,
    input logic [NCH-1:0] ln0_o,
    input logic [NCH-1:0] ln0_frm_o,
    input logic [NCH-1:0] ln0_en_o,
    input logic [NCH-1:0] rng_o
);

    // R3: secondary lane stays disabled in single-lane mode.
    p_lo_off_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !dual_i |-> (ln0_en_o == '0));

    // R4: no secondary frame strobe in single-lane mode.
    p_lo_frm_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !dual_i |-> (ln0_frm_o == '0));

    // R4: lane frames of one channel never overlap.
    p_frames_apart_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (ln1_frm_o & ln0_frm_o) == '0);

    // R4: single-lane frame lasts one clock.
    p_frm_short_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ((ln1_frm_o != '0) && !dual_i && !pwr_dn_i) |=> (ln1_frm_o == '0));

    // R5: power-down freezes every output.
    p_hold_pd_r5: assert property (@(posedge clk) disable iff (!rst_n)
        pwr_dn_i |=> ($stable(ln1_o) && $stable(ln0_o) && $stable(rng_o)
                      && $stable(ln1_frm_o) && $stable(ln0_frm_o)
                      && $stable(ln0_en_o)));

    // R6: range flag moves only after a capture edge.
    p_rng_on_cap_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(rng_o) |-> $past(cap_evt));

endmodule

bind ser_lanes ser_lanes_chk #(.NCH(NCH)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .pwr_dn_i  (pwr_dn_i),
    .dual_i    (dual_i),
    .cap_evt   (cap_evt),
    .ln1_o     (ln1_o),
    .ln1_frm_o (ln1_frm_o),
    .ln0_o     (ln0_o),
    .ln0_frm_o (ln0_frm_o),
    .ln0_en_o  (ln0_en_o),
    .rng_o     (rng_o)
);

// File: tb/ser_lanes_test.sv
`timescale 1ns/1ps
// Bench for ser_lanes: seeded random samples and power-down, directed corner
// patterns, every output compared each cycle against a model indexed by the
// count of active (non-frozen) edges.
module ser_lanes_test;

    localparam int W    = 12;
    localparam int NCH  = 2;
    localparam int HMAX = 256;

    logic                 clk = 1'b0;
    logic                 rst_n = 1'b0;
    logic                 pwr_dn_i = 1'b0;
    logic                 dual_i = 1'b0;
    logic [NCH*W-1:0]     smp_i = '0;
    logic [NCH-1:0]       ovr_i = '0;
    logic [NCH-1:0]       ln1_o, ln1_frm_o, ln0_o, ln0_frm_o, ln0_en_o, rng_o;

    int n_chk  = 0;
    int n_fail = 0;
    int n_act  = 0;
    bit done   = 1'b0;
    bit last_pd = 1'b0;

    logic [W-1:0] hist_s [NCH][HMAX];
    logic         hist_o [NCH][HMAX];

    ser_lanes #(.SMP_W(W), .NCH(NCH)) uut (
        .clk(clk), .rst_n(rst_n), .pwr_dn_i(pwr_dn_i), .dual_i(dual_i),
        .smp_i(smp_i), .ovr_i(ovr_i), .ln1_o(ln1_o), .ln1_frm_o(ln1_frm_o),
        .ln0_o(ln0_o), .ln0_frm_o(ln0_frm_o), .ln0_en_o(ln0_en_o), .rng_o(rng_o)
    );

    always #10 clk = ~clk;

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        #(20 * 200000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired: actual=running expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

    task automatic chk(string tag, int ch, logic act, logic exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s ch%0d n=%0d actual=%b expected=%b", tag, ch, n_act, act, exp);
        end
    endtask

    function automatic logic sample_bit(int ch, int k, int b);
        if (k >= HMAX) return 1'b0;
        return hist_s[ch][k][b];
    endfunction

    // Expected primary lane bit (R1 single, R2 dual).
    function automatic logic e_ln1(int ch, int n, bit d);
        int j;
        if (n == 0) return 1'b0;
        j = n - 1;
        if (!d) return sample_bit(ch, j / W, W - 1 - (j % W));
        return sample_bit(ch, 2 * (j / (2 * W)), W - 1 - ((j % (2 * W)) / 2));
    endfunction

    // Expected secondary lane bit in dual mode (R2).
    function automatic logic e_ln0(int ch, int n);
        int j;
        if (n <= W) return 1'b0;
        j = n - 1 - W;
        return sample_bit(ch, 2 * (j / (2 * W)) + 1, W - 1 - ((j % (2 * W)) / 2));
    endfunction

    function automatic logic e_frm1(int n, bit d);
        if (n == 0) return 1'b0;
        return d ? (((n - 1) % (2 * W)) < 2) : (((n - 1) % W) == 0);
    endfunction

    function automatic logic e_frm0(int n, bit d);
        if (!d || n <= W) return 1'b0;
        return ((n - 1 - W) % (2 * W)) < 2;
    endfunction

    function automatic logic e_rng(int ch, int n);
        if (n == 0 || (n - 1) / W >= HMAX) return 1'b0;
        return hist_o[ch][(n - 1) / W];
    endfunction

    // Compare every output against the model.
    task automatic check_all();
        for (int c = 0; c < NCH; c++) begin
            if (last_pd) begin
                chk("R5 ln1", c, ln1_o[c], e_ln1(c, n_act, dual_i));
            end else if (dual_i) begin
                chk("R2 R7 ln1", c, ln1_o[c], e_ln1(c, n_act, dual_i));
            end else begin
                chk("R1 R7 ln1", c, ln1_o[c], e_ln1(c, n_act, dual_i));
            end
            if (dual_i) chk("R2 ln0", c, ln0_o[c], e_ln0(c, n_act));
            chk("R3 en0", c, ln0_en_o[c], dual_i && (n_act > 0));
            chk("R4 frm1", c, ln1_frm_o[c], e_frm1(n_act, dual_i));
            chk("R4 frm0", c, ln0_frm_o[c], e_frm0(n_act, dual_i));
            chk("R6 rng", c, rng_o[c], e_rng(c, n_act));
        end
    endtask

    // Drive inputs (at a falling edge), clock once, update the model, check.
    task automatic step(bit pd);
        int k;
        k = n_act / W;
        pwr_dn_i = pd;
        for (int c = 0; c < NCH; c++) begin
            logic [W-1:0] v;
            case (k)
                0: v = (c == 0) ? 12'hFFF : 12'h000;
                1: v = (c == 0) ? 12'h000 : 12'hFFF;
                2: v = (c == 0) ? 12'hA5A : 12'h5A5;
                default: v = W'($urandom);
            endcase
            smp_i[c*W +: W] = v;
            ovr_i[c] = ($urandom % 3) == 0;
        end
        @(posedge clk);
        if (rst_n && !pd) begin
            if ((n_act % W) == 0 && k < HMAX) begin
                for (int c = 0; c < NCH; c++) begin
                    hist_s[c][k] = smp_i[c*W +: W];
                    hist_o[c][k] = ovr_i[c];
                end
            end
            n_act++;
        end
        last_pd = pd;
        @(negedge clk);
        check_all();
    endtask

    // Reset into a mode and check the reset state (R8).
    task automatic do_reset(bit d);
        @(negedge clk);
        rst_n = 1'b0;
        pwr_dn_i = 1'b0;
        dual_i = d;
        repeat (2) @(posedge clk);
        @(negedge clk);
        n_act = 0;
        last_pd = 1'b0;
        for (int c = 0; c < NCH; c++) begin
            chk("R8 ln1", c, ln1_o[c], 1'b0);
            chk("R8 ln0", c, ln0_o[c], 1'b0);
            chk("R8 frm", c, ln1_frm_o[c] | ln0_frm_o[c], 1'b0);
            chk("R8 en0", c, ln0_en_o[c], 1'b0);
            chk("R8 rng", c, rng_o[c], 1'b0);
        end
        rst_n = 1'b1;
    endtask

    // One run: pd_pct random power-down, cap_pct extra power-down on capture edges.
    task automatic run(bit d, int cycles, int pd_pct, int cap_pct, int pre_pd);
        do_reset(d);
        for (int i = 0; i < pre_pd; i++) step(1'b1);
        for (int i = 0; i < cycles; i++) begin
            bit pd;
            pd = ($urandom % 100) < pd_pct;
            if ((n_act % W) == 0 && ($urandom % 100) < cap_pct) pd = 1'b1;
            step(pd);
        end
    endtask

    initial begin
        void'($urandom(32'd4711));
        run(1'b0, 400, 0, 0, 0);
        run(1'b0, 700, 10, 60, 3);
        run(1'b1, 800, 0, 0, 0);
        run(1'b1, 1000, 10, 60, 4);
        // Long freeze straddling a capture point in dual mode (R5).
        do_reset(1'b1);
        for (int i = 0; i < 3 * W - 1; i++) step(1'b0);
        for (int i = 0; i < 40; i++) step(1'b1);
        for (int i = 0; i < 5 * W; i++) step(1'b0);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

endmodule